// File: doc/BRIEF.md
# Host-Slave Dual Buffer Interface

This block is the host-facing register window of an 8-bit slave controller. A host processor reaches it through an active-low chip select, one address bit and active-low read and write strobes. The local controller reaches it through two streams and a few command pulses. Each direction has its own storage. Bytes written by the host land in the inbound buffer, and the local side takes them over a valid/ready stream. Bytes the local side offers go into the outbound buffer, which the host reads back.

An 8-bit status byte shows the host the state of both buffers. It also carries a flag that says whether the last host write was a command or data, a flag the local side owns, and four user bits that the local side writes. The host strobes are asynchronous and edge-sensitive. They pass through a two-flop synchronizer, and every flag change that a host access causes is committed only after that strobe's trailing edge. While the host is reading status, local updates to the status byte are parked and then applied on the first cycle after the read ends. The local side gets back-pressure on its outbound stream: `tx_ready` is low while the outbound byte is still unread.

Top module: `hsdb_top`

## Requirements
- R1: A host write (`host_cs_n`=0, `host_wr_n` pulsed low) stores `host_din` in the inbound buffer. After the trailing edge, the IBF flag (status bit 1) is 1 and the F1 flag (status bit 3) equals `host_a0`. 0 marks data and 1 marks a command, and the same value appears on `rx_cmd`.
- R2: IBF, OBF and F1 do not change while a strobe is still low. Host-caused changes appear no sooner than two clock edges after the strobe's rising edge and no later than four.
- R3: While `host_cs_n`=0, `host_rd_n`=0 and `host_a0`=0, `host_dout` shows the outbound buffer. After the trailing edge of that read, OBF (status bit 0) is 0.
- R4: While `host_cs_n`=0, `host_rd_n`=0 and `host_a0`=1, `host_dout` shows the status byte. Its layout is bits 7..4 user bits, bit 3 F1, bit 2 F0, bit 1 IBF, bit 0 OBF. Such a read changes nothing.
- R5: `rx_valid` follows IBF and `rx_data` shows the inbound buffer. A cycle with `rx_valid`=1 and `rx_ready`=1 clears IBF at that clock edge.
- R6: `tx_ready` is 1 only when OBF is 0. A cycle with `tx_valid`=1 and `tx_ready`=1 loads `tx_data` into the outbound buffer and sets OBF. While `tx_ready` is 0, `tx_data` is ignored and the stored byte is kept.
- R7: A one-cycle `sts_wr` pulse copies `sts_user` (the accumulator's upper nibble) into status bits 7..4 at the next edge. Status bits 3..0 are unchanged.
- R8: A one-cycle `f0_wr` pulse sets F0 (status bit 2) to `f0_val`.
- R9: While a host status read is in progress, no local update to the status byte takes effect. This covers user bits, F0, the IBF clear and the OBF set. Pending updates are applied on the first cycle after the read ends, and the last write of each field wins.
- R10: `host_irq` equals OBF.
- R11: After reset, all status bits are 0, `rx_valid`=0, `tx_ready`=1 and `host_irq`=0.
- R12: Strobes with `host_cs_n`=1 have no effect on buffers or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_a0 | input | 1 | Host address bit: 0 data, 1 command/status |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data (outbound buffer or status) |
| host_doe | output | 1 | Host data drive enable during reads |
| host_irq | output | 1 | Outbound data available to host |
| rx_data | output | 8 | Inbound buffer contents |
| rx_cmd | output | 1 | Inbound byte is a command (F1) |
| rx_valid | output | 1 | Inbound byte waiting |
| rx_ready | input | 1 | Local side takes the inbound byte |
| tx_data | input | 8 | Byte offered for the outbound buffer |
| tx_valid | input | 1 | Outbound byte offered |
| tx_ready | output | 1 | Outbound buffer empty, offer accepted |
| sts_wr | input | 1 | Pulse: write user status bits |
| sts_user | input | 4 | New user status bits |
| f0_wr | input | 1 | Pulse: write F0 |
| f0_val | input | 1 | New F0 value |

## Verification
The bench watches the inbound flag while the write strobe is still held low. A design that acted on the falling edge would raise it too early. It parks a user-bit write, an F0 write and an outbound load in the middle of a status read. A design without lockout would show the new user bits while the host is still reading, or would drop the parked updates after the read. It offers a second outbound byte while the first is unread, then checks that the host still reads the first one. A design that overwrote the buffer would hand back the wrong byte. It also strobes with chip select inactive, and it reads status twice to confirm that reading status has no side effects.

// File: rtl/hsdb_pkg.sv
package hsdb_pkg;
  // Status byte bit positions (host software decodes these)
  localparam int unsigned STS_OBF = 0;
  localparam int unsigned STS_IBF = 1;
  localparam int unsigned STS_F0  = 2;
  localparam int unsigned STS_F1  = 3;
  localparam int unsigned STS_USR = 4;
endpackage

// File: rtl/hsdb_strobe_sync.sv
module hsdb_strobe_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic [PW-1:0] payload,
  output logic          active,
  output logic          rise,
  output logic [PW-1:0] payload_sync
);
  localparam int unsigned BW = PW + 1;

  logic [STAGES-1:0][BW-1:0] stg;
  logic                      prev_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= {1'b1, {PW{1'b0}}};
      prev_strobe <= 1'b1;
    end else begin
      stg[0] <= {strobe_n, payload};
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      prev_strobe <= stg[STAGES-1][PW];
    end
  end

  assign active       = ~stg[STAGES-1][PW];
  assign rise         = stg[STAGES-1][PW] & ~prev_strobe;
  assign payload_sync = stg[STAGES-1][PW-1:0];
endmodule

// File: rtl/hsdb_databuf.sv
module hsdb_databuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/hsdb_status.sv
module hsdb_status #(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock,
  input  logic            host_wr_done,
  input  logic            host_wr_a0,
  input  logic            host_rd_data_done,
  input  logic            loc_ibf_clr,
  input  logic            loc_obf_set,
  input  logic            loc_sts_wr,
  input  logic [DW-5:0]   loc_sts_val,
  input  logic            loc_f0_wr,
  input  logic            loc_f0_val,
  output logic [DW-1:0]   status,
  output logic            pend_ibf_clr,
  output logic            pend_obf_set
);
  localparam int unsigned UW = DW - 4;

  logic [UW-1:0] usr_q, usr_d, pend_usr;
  logic          pend_usr_v;
  logic          f0_q, f0_d, pend_f0, pend_f0_v;
  logic          f1_q, ibf_q, obf_q;
  logic          ibf_clr, obf_set;

  always_comb begin
    usr_d   = usr_q;
    f0_d    = f0_q;
    ibf_clr = 1'b0;
    obf_set = 1'b0;
    if (!lock) begin
      if (pend_usr_v) usr_d = pend_usr;
      if (loc_sts_wr) usr_d = loc_sts_val;
      if (pend_f0_v)  f0_d  = pend_f0;
      if (loc_f0_wr)  f0_d  = loc_f0_val;
      ibf_clr = loc_ibf_clr | pend_ibf_clr;
      obf_set = loc_obf_set | pend_obf_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_q <= '0;
      f0_q  <= 1'b0;
      f1_q  <= 1'b0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else begin
      usr_q <= usr_d;
      f0_q  <= f0_d;
      ibf_q <= (ibf_q & ~ibf_clr) | host_wr_done;
      obf_q <= (obf_q & ~host_rd_data_done) | obf_set;
      if (host_wr_done) f1_q <= host_wr_a0;
    end
  end

  // Parking area for local updates raised during a host status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_usr     <= '0;
      pend_usr_v   <= 1'b0;
      pend_f0      <= 1'b0;
      pend_f0_v    <= 1'b0;
      pend_ibf_clr <= 1'b0;
      pend_obf_set <= 1'b0;
    end else if (lock) begin
      if (loc_sts_wr) begin
        pend_usr   <= loc_sts_val;
        pend_usr_v <= 1'b1;
      end
      if (loc_f0_wr) begin
        pend_f0   <= loc_f0_val;
        pend_f0_v <= 1'b1;
      end
      pend_ibf_clr <= pend_ibf_clr | loc_ibf_clr;
      pend_obf_set <= pend_obf_set | loc_obf_set;
    end else begin
      pend_usr_v   <= 1'b0;
      pend_f0_v    <= 1'b0;
      pend_ibf_clr <= 1'b0;
      pend_obf_set <= 1'b0;
    end
  end

  assign status = {usr_q, f1_q, f0_q, ibf_q, obf_q};
endmodule

// File: rtl/hsdb_top.sv
module hsdb_top #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          host_a0,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  output logic          host_irq,
  output logic [DW-1:0] rx_data,
  output logic          rx_cmd,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          sts_wr,
  input  logic [DW-5:0] sts_user,
  input  logic          f0_wr,
  input  logic          f0_val
);
  import hsdb_pkg::*;

  localparam int unsigned WPW = DW + 2;  // {cs, a0, data}
  localparam int unsigned RPW = 2;       // {cs, a0}

  logic           wr_active, wr_rise, rd_active, rd_rise;
  logic [WPW-1:0] wr_live, wr_hold;
  logic [RPW-1:0] rd_live, rd_hold;
  logic           wr_done, wr_a0, rd_data_done, lock;
  logic           rx_fire, tx_fire;
  logic           pend_ibf_clr, pend_obf_set;
  logic [DW-1:0]  status, outbuf_q;

  hsdb_strobe_sync #(.STAGES(SYNC_STAGES), .PW(WPW)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n),
    .payload({~host_cs_n, host_a0, host_din}),
    .active(wr_active), .rise(wr_rise), .payload_sync(wr_live)
  );

  hsdb_strobe_sync #(.STAGES(SYNC_STAGES), .PW(RPW)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n),
    .payload({~host_cs_n, host_a0}),
    .active(rd_active), .rise(rd_rise), .payload_sync(rd_live)
  );

  // Keep the last payload seen while each strobe was low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hold <= '0;
      rd_hold <= '0;
    end else begin
      if (wr_active) wr_hold <= wr_live;
      if (rd_active) rd_hold <= rd_live;
    end
  end

  assign wr_done      = wr_rise & wr_hold[DW+1];
  assign wr_a0        = wr_hold[DW];
  assign rd_data_done = rd_rise & rd_hold[1] & ~rd_hold[0];
  assign lock         = rd_active & rd_live[1] & rd_live[0];

  assign rx_valid = status[STS_IBF] & ~pend_ibf_clr;
  assign rx_fire  = rx_valid & rx_ready;
  assign tx_ready = ~status[STS_OBF] & ~pend_obf_set;
  assign tx_fire  = tx_valid & tx_ready;

  hsdb_databuf #(.DW(DW)) u_inbuf (
    .clk(clk), .rst_n(rst_n), .load(wr_done),
    .d(wr_hold[DW-1:0]), .q(rx_data)
  );

  hsdb_databuf #(.DW(DW)) u_outbuf (
    .clk(clk), .rst_n(rst_n), .load(tx_fire),
    .d(tx_data), .q(outbuf_q)
  );

  hsdb_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .lock(lock),
    .host_wr_done(wr_done), .host_wr_a0(wr_a0),
    .host_rd_data_done(rd_data_done),
    .loc_ibf_clr(rx_fire), .loc_obf_set(tx_fire),
    .loc_sts_wr(sts_wr), .loc_sts_val(sts_user),
    .loc_f0_wr(f0_wr), .loc_f0_val(f0_val),
    .status(status), .pend_ibf_clr(pend_ibf_clr), .pend_obf_set(pend_obf_set)
  );

  assign rx_cmd    = status[STS_F1];
  assign host_irq  = status[STS_OBF];
  assign host_dout = host_a0 ? status : outbuf_q;
  assign host_doe  = ~host_cs_n & ~host_rd_n;
endmodule

// File: rtl/hsdb_chk.sv
module hsdb_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock,
  input logic [DW-1:0] status,
  input logic          wr_done,
  input logic          wr_a0,
  input logic          rd_data_done,
  input logic          tx_fire,
  input logic          tx_ready,
  input logic          pend_obf_set,
  input logic          rx_fire,
  input logic          sts_wr,
  input logic [DW-5:0] sts_user
);
  import hsdb_pkg::*;

  p_host_write_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (status[STS_F1] == $past(wr_a0)) && status[STS_IBF]);

  p_obf_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_done && !tx_fire && !pend_obf_set |=> !status[STS_OBF]);

  p_rx_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire && !wr_done && !lock |=> !status[STS_IBF]);

  p_tx_backpressure_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[STS_OBF] |-> !tx_ready);

  p_user_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && !lock |=> status[DW-1:STS_USR] == $past(sts_user));

  p_status_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock && $past(lock) && !$past(wr_done) |-> status == $past(status));
endmodule

bind hsdb_top hsdb_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .status(status),
  .wr_done(wr_done), .wr_a0(wr_a0), .rd_data_done(rd_data_done),
  .tx_fire(tx_fire), .tx_ready(tx_ready), .pend_obf_set(pend_obf_set),
  .rx_fire(rx_fire), .sts_wr(sts_wr), .sts_user(sts_user)
);

// File: tb/tb_hsdb_top.sv
module tb_hsdb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs_n = 1'b1, host_a0 = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_din = 8'h00;
  logic [7:0] host_dout;
  logic       host_doe, host_irq;
  logic [7:0] rx_data;
  logic       rx_cmd, rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       sts_wr = 1'b0;
  logic [3:0] sts_user = 4'h0;
  logic       f0_wr = 1'b0, f0_val = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hsdb_top dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_a0(host_a0),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .host_irq(host_irq),
    .rx_data(rx_data), .rx_cmd(rx_cmd), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sts_wr(sts_wr), .sts_user(sts_user), .f0_wr(f0_wr), .f0_val(f0_val)
  );

  // {a0, data} host write vectors
  localparam logic [8:0] WR_VEC [6] = '{
    {1'b0, 8'h3C}, {1'b1, 8'hA5}, {1'b0, 8'h00},
    {1'b1, 8'hFF}, {1'b0, 8'h81}, {1'b1, 8'h5E}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic a0, input logic [7:0] d, input logic cs_n);
    @(negedge clk);
    host_cs_n = cs_n; host_a0 = a0; host_din = d; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1; host_cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_read(input logic a0, output logic [7:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = a0; host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = host_dout;
    host_rd_n = 1'b1; host_cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic take_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, rd2;
    logic       last_a0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11 rx_valid", {7'b0, rx_valid}, 8'h00);
    chk("R11 tx_ready", {7'b0, tx_ready}, 8'h01);
    chk("R11 host_irq", {7'b0, host_irq}, 8'h00);
    host_read(1'b1, rd);
    chk("R11 status", rd, 8'h00);

    // R1/R4/R5: vector table of host writes
    last_a0 = 1'b0;
    for (int i = 0; i < 6; i++) begin
      host_write(WR_VEC[i][8], WR_VEC[i][7:0], 1'b0);
      chk("R1 rx_valid", {7'b0, rx_valid}, 8'h01);
      chk("R1 rx_data", rx_data, WR_VEC[i][7:0]);
      chk("R1 rx_cmd", {7'b0, rx_cmd}, {7'b0, WR_VEC[i][8]});
      host_read(1'b1, rd);
      chk("R4 status layout", rd, {4'h0, WR_VEC[i][8], 1'b0, 1'b1, 1'b0});
      host_read(1'b1, rd2);
      chk("R4 status read no side effect", rd2, rd);
      take_rx();
      chk("R5 ibf cleared by take", {7'b0, rx_valid}, 8'h00);
      last_a0 = WR_VEC[i][8];
    end

    // R2: flag held until after trailing edge, then within 4 edges
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = 1'b0; host_din = 8'h77; host_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 ibf while strobe low", {7'b0, rx_valid}, 8'h00);
    host_wr_n = 1'b1; host_cs_n = 1'b1;
    @(negedge clk);
    chk("R2 ibf one edge after release", {7'b0, rx_valid}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R2 ibf after sync", {7'b0, rx_valid}, 8'h01);
    chk("R2 data", rx_data, 8'h77);
    last_a0 = 1'b0;
    take_rx();

    // R6/R10: outbound load and back-pressure
    tx_data = 8'h5A; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R10 irq follows obf", {7'b0, host_irq}, 8'h01);
    chk("R6 tx_ready low when full", {7'b0, tx_ready}, 8'h00);
    tx_data = 8'hC3; tx_valid = 1'b1;
    repeat (2) @(negedge clk);
    tx_valid = 1'b0;
    host_read(1'b1, rd);
    chk("R4 status shows obf", rd, {4'h0, last_a0, 1'b0, 1'b0, 1'b1});
    host_read(1'b0, rd);
    chk("R6 blocked byte ignored", rd, 8'h5A);
    chk("R3 obf cleared after read", {7'b0, host_irq}, 8'h00);
    chk("R3 tx_ready back", {7'b0, tx_ready}, 8'h01);

    // R7: user bits
    sts_user = 4'hB; sts_wr = 1'b1;
    @(negedge clk);
    sts_wr = 1'b0;
    host_read(1'b1, rd);
    chk("R7 user bits", rd, {4'hB, last_a0, 1'b0, 1'b0, 1'b0});

    // R8: F0 set then clear
    f0_val = 1'b1; f0_wr = 1'b1;
    @(negedge clk);
    f0_wr = 1'b0;
    host_read(1'b1, rd);
    chk("R8 f0 set", rd, {4'hB, last_a0, 1'b1, 1'b0, 1'b0});
    f0_val = 1'b0; f0_wr = 1'b1;
    @(negedge clk);
    f0_wr = 1'b0;
    host_read(1'b1, rd);
    chk("R8 f0 clear", rd, {4'hB, last_a0, 1'b0, 1'b0, 1'b0});

    // R9: lockout during status read
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = 1'b1; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    sts_user = 4'h2; sts_wr = 1'b1; f0_val = 1'b1; f0_wr = 1'b1;
    @(negedge clk);
    sts_user = 4'h4;
    f0_wr = 1'b0;
    @(negedge clk);
    sts_wr = 1'b0;
    tx_data = 8'h96; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 status frozen in read", host_dout, {4'hB, last_a0, 1'b0, 1'b0, 1'b0});
    chk("R9 obf set parked", {7'b0, host_irq}, 8'h00);
    host_rd_n = 1'b1; host_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 obf applied after read", {7'b0, host_irq}, 8'h01);
    host_read(1'b1, rd);
    chk("R9 parked updates applied", rd, {4'h4, last_a0, 1'b1, 1'b0, 1'b1});
    host_read(1'b0, rd);
    chk("R9 parked tx byte", rd, 8'h96);

    // R12: strobes with chip select inactive
    host_write(1'b1, 8'hEE, 1'b1);
    chk("R12 no ibf without cs", {7'b0, rx_valid}, 8'h00);
    chk("R12 inbuf kept", rx_data, 8'h77);
    host_read(1'b1, rd);
    chk("R12 status kept", rd, {4'h4, last_a0, 1'b1, 1'b0, 1'b0});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule